// File: doc/BRIEF.md
# Stereo PCM Subframe Formatter

This block turns a stereo stream of PCM samples into the 32-slot subframes carried by a consumer digital audio link. Each frame holds a left subframe followed by a right subframe. The block counts frames through a 192-frame status block and tags every subframe with one of three sync kinds: block start, first channel or second channel. It fills in the audio sample, the validity flag, the user bit, one channel-status bit per frame and an even-parity bit.

Finished subframes leave on a registered valid/ready port. Slots 0 to 3 of the output word are left at zero, and the sync kind is carried on a separate tag. A later line coder puts the real preamble pattern into those slots. The sample pair, the sample width, the validity flag and the status word are read once, at the start of each frame.

Top module: `aud_subframe_fmt`

## Requirements
- R1: While `rst` is high, and during the first cycle after it falls, `out_valid` is low. The first subframe offered after reset is the left subframe of frame 0.
- R2: The sync tag on `out_sync` uses these codes: 0 for block start, 1 for first channel, 2 for second channel. The left subframe of frame 0 is tagged 0, the left subframe of every other frame is tagged 1, and every right subframe is tagged 2.
- R3: The frame index runs from 0 to 191 and then wraps to 0. It steps once the right subframe has been accepted, so a block-start tag appears once every 192 frames.
- R4: With `cfg_wide` = 1, slots 27:4 of `out_word` hold `sample[23:0]`, with the MSB in slot 27.
- R5: With `cfg_wide` = 0, slots 27:12 hold `sample[15:0]` and slots 11:4 are zero. Input bits 23:16 have no effect.
- R6: Slot 28 equals `cfg_validity`, slot 29 is always 0, and slots 3:0 are always 0.
- R7: Slot 30 of both subframes of frame n equals `cs_block[n]`.
- R8: Slot 31 makes the count of ones in slots 31:4 even.
- R9: While `out_valid` is high and `out_ready` is low, `out_word` and `out_sync` hold steady and `out_valid` stays high.
- R10: All inputs are sampled on the clock edge that loads the left subframe. Changes made to them before the right subframe has been accepted do not reach the right subframe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wide | input | 1 | 1 selects 24-bit samples, 0 selects 16-bit samples |
| cfg_validity | input | 1 | Validity flag placed in slot 28 |
| smp_left | input | 24 | Left sample, two's complement |
| smp_right | input | 24 | Right sample, two's complement |
| cs_block | input | 192 | Channel-status block; bit n goes with frame n |
| out_valid | output | 1 | A subframe is offered |
| out_ready | input | 1 | The consumer accepts the offered subframe |
| out_word | output | 32 | Subframe slots 31:0 |
| out_sync | output | 2 | Sync kind tag (0 block, 1 first channel, 2 second channel) |

## Verification
The bench builds the block with its default parameters: 192 frames per block, 24-bit samples and 16-bit narrow samples. This lets several full blocks run in a short test, so the wrap of the frame index and the return of the block-start tag are seen more than once. Both sample widths are exercised with random upper bits. The inputs change on every cycle and the ready signal stalls at random, which puts mid-frame changes and held outputs within reach of the checks.

// File: rtl/aud_sf_pkg.sv
package aud_sf_pkg;
  typedef enum logic [1:0] {
    SYNC_BLOCK = 2'd0,
    SYNC_CHAN1 = 2'd1,
    SYNC_CHAN2 = 2'd2
  } sync_kind_e;

  localparam int SUBFRAME_SLOTS = 32;
  localparam int SLOT_SMP_LO    = 4;
  localparam int SLOT_SMP_HI    = 27;
  localparam int SLOT_VALID     = 28;
  localparam int SLOT_USER      = 29;
  localparam int SLOT_STATUS    = 30;
  localparam int SLOT_PARITY    = 31;
endpackage

// File: rtl/aud_sf_seq.sv
module aud_sf_seq #(
  parameter int FRAMES = 192,
  localparam int FW = $clog2(FRAMES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fire,
  output logic          valid_q,
  output logic          half_q,
  output logic [FW-1:0] frame_q,
  output logic [FW-1:0] nxt_frame,
  output logic          load
);
  localparam logic [FW-1:0] LAST = FW'(FRAMES - 1);

  always_comb begin
    load = !valid_q || (fire && half_q);
    if (!valid_q)            nxt_frame = '0;
    else if (frame_q == LAST) nxt_frame = '0;
    else                      nxt_frame = frame_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      half_q  <= 1'b0;
      frame_q <= '0;
    end else if (load) begin
      valid_q <= 1'b1;
      half_q  <= 1'b0;
      frame_q <= nxt_frame;
    end else if (fire) begin
      half_q  <= 1'b1;
    end
  end

  AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (rst)
    fire && half_q && frame_q == LAST |=> frame_q == '0); // R3
  AST_FRAME_STEP: assert property (@(posedge clk) disable iff (rst)
    fire && half_q && frame_q != LAST |=> frame_q == $past(frame_q) + 1'b1); // R3
  AST_HALF_HOLD: assert property (@(posedge clk) disable iff (rst)
    valid_q && !fire |=> valid_q && half_q == $past(half_q)); // R9
endmodule

// File: rtl/aud_sf_pack.sv
module aud_sf_pack #(
  parameter int SAMPLE_W = 24,
  parameter int NARROW_W = 16
) (
  input  logic [SAMPLE_W-1:0] sample,
  input  logic                wide,
  input  logic                validity,
  input  logic                status_bit,
  output logic [31:0]         word
);
  import aud_sf_pkg::*;
  localparam int PAD = SAMPLE_W - NARROW_W;

  logic [SAMPLE_W-1:0] field;
  logic [30:0]         body;

  generate
    if (PAD > 0) begin : g_pad
      assign field = wide ? sample : {sample[NARROW_W-1:0], {PAD{1'b0}}};
    end else begin : g_nopad
      assign field = sample;
    end
  endgenerate

  always_comb begin
    body                           = '0;
    body[SLOT_SMP_HI:SLOT_SMP_LO]  = field;
    body[SLOT_VALID]               = validity;
    body[SLOT_USER]                = 1'b0;
    body[SLOT_STATUS]              = status_bit;
    word = {^body[SLOT_STATUS:SLOT_SMP_LO], body};
  end
endmodule

// File: rtl/aud_subframe_fmt.sv
module aud_subframe_fmt #(
  parameter int FRAMES   = 192,
  parameter int SAMPLE_W = 24,
  parameter int NARROW_W = 16,
  localparam int FW = $clog2(FRAMES)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_wide,
  input  logic                cfg_validity,
  input  logic [SAMPLE_W-1:0] smp_left,
  input  logic [SAMPLE_W-1:0] smp_right,
  input  logic [FRAMES-1:0]   cs_block,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [31:0]         out_word,
  output logic [1:0]          out_sync
);
  import aud_sf_pkg::*;

  logic          fire, half_q, load, valid_q;
  logic [FW-1:0] frame_q, nxt_frame;
  logic          cs_now;

  logic [SAMPLE_W-1:0] hold_right;
  logic                hold_wide, hold_valid, hold_cs;
  logic [31:0]         word_left, word_right;

  assign fire      = out_valid && out_ready;
  assign out_valid = valid_q;
  assign cs_now    = cs_block[nxt_frame];

  aud_sf_seq #(.FRAMES(FRAMES)) u_seq (
    .clk(clk), .rst(rst), .fire(fire), .valid_q(valid_q), .half_q(half_q),
    .frame_q(frame_q), .nxt_frame(nxt_frame), .load(load)
  );

  aud_sf_pack #(.SAMPLE_W(SAMPLE_W), .NARROW_W(NARROW_W)) u_pack_l (
    .sample(smp_left), .wide(cfg_wide), .validity(cfg_validity),
    .status_bit(cs_now), .word(word_left)
  );

  aud_sf_pack #(.SAMPLE_W(SAMPLE_W), .NARROW_W(NARROW_W)) u_pack_r (
    .sample(hold_right), .wide(hold_wide), .validity(hold_valid),
    .status_bit(hold_cs), .word(word_right)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_right <= '0;
      hold_wide  <= 1'b0;
      hold_valid <= 1'b0;
      hold_cs    <= 1'b0;
      out_word   <= '0;
      out_sync   <= SYNC_BLOCK;
    end else if (load) begin
      hold_right <= smp_right;
      hold_wide  <= cfg_wide;
      hold_valid <= cfg_validity;
      hold_cs    <= cs_now;
      out_word   <= word_left;
      out_sync   <= (nxt_frame == '0) ? SYNC_BLOCK : SYNC_CHAN1;
    end else if (fire) begin
      out_word   <= word_right;
      out_sync   <= SYNC_CHAN2;
    end
  end

  AST_LEFT_THEN_RIGHT: assert property (@(posedge clk) disable iff (rst)
    fire && out_sync != SYNC_CHAN2 |=> out_sync == SYNC_CHAN2); // R2
  AST_RIGHT_THEN_LEFT: assert property (@(posedge clk) disable iff (rst)
    fire && out_sync == SYNC_CHAN2 |=> out_sync != SYNC_CHAN2); // R2
  AST_EVEN_PARITY: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ^out_word[31:4] == 1'b0); // R8
  AST_FIXED_SLOTS: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_word[29] == 1'b0 && out_word[3:0] == 4'h0); // R6
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_word) && $stable(out_sync)); // R9
  AST_STATUS_PAIR: assert property (@(posedge clk) disable iff (rst)
    fire && out_sync != SYNC_CHAN2 |=> out_word[30] == $past(out_word[30])); // R7
endmodule

// File: tb/aud_subframe_fmt_tb.sv
module aud_subframe_fmt_tb;
  localparam int FRAMES = 192;

  logic         clk = 1'b0;
  logic         rst;
  logic         cfg_wide, cfg_validity, out_ready;
  logic [23:0]  smp_left, smp_right;
  logic [191:0] cs_block;
  logic         out_valid;
  logic [31:0]  out_word;
  logic [1:0]   out_sync;

  int vectors = 0;
  int errors  = 0;

  always #10 clk = ~clk;

  aud_subframe_fmt u_dut (
    .clk(clk), .rst(rst), .cfg_wide(cfg_wide), .cfg_validity(cfg_validity),
    .smp_left(smp_left), .smp_right(smp_right), .cs_block(cs_block),
    .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word),
    .out_sync(out_sync)
  );

  function automatic logic [31:0] exp_word(logic [23:0] s, logic w, logic v, logic c);
    logic [31:0] r = '0;
    for (int k = 0; k < 24; k++) begin
      if (w) r[4 + k] = s[k];
      else if (k >= 8) r[4 + k] = s[k - 8];
    end
    r[28] = v;
    r[29] = 1'b0;
    r[30] = c;
    r[31] = ^r[30:4];
    return r;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // model state
  logic         m_valid = 1'b0, m_half = 1'b0;
  int           m_frame = 0;
  logic [23:0]  h_l, h_r;
  logic         h_w, h_v, h_c;

  task automatic randomize_inputs();
    smp_left     = 24'($urandom);
    smp_right    = 24'($urandom);
    cfg_wide     = 1'($urandom);
    cfg_validity = 1'($urandom);
    cs_block     = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
  endtask

  task automatic step(logic rdy);
    logic ld, adv;
    out_ready = rdy;
    randomize_inputs(); // R10: inputs change every cycle
    ld  = !m_valid || (rdy && m_half);
    adv = m_valid && rdy && !m_half;
    if (ld) begin
      m_frame = m_valid ? (m_frame + 1) % FRAMES : 0;
      m_half  = 1'b0;
      m_valid = 1'b1;
      h_l = smp_left; h_r = smp_right; h_w = cfg_wide; h_v = cfg_validity;
      h_c = cs_block[m_frame];
    end else if (adv) begin
      m_half = 1'b1;
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check_out();
    logic [31:0] e;
    logic [1:0]  es;
    chk("R9 valid", {31'd0, out_valid}, {31'd0, m_valid});
    if (!m_valid) return;
    e  = exp_word(m_half ? h_r : h_l, h_w, h_v, h_c);
    es = m_half ? 2'd2 : (m_frame == 0 ? 2'd0 : 2'd1);
    chk(m_frame == 0 ? "R3 sync" : "R2 sync", {30'd0, out_sync}, {30'd0, es});
    chk(h_w ? "R4 sample" : "R5 sample", {8'd0, out_word[27:4]}, {8'd0, e[27:4]});
    chk("R6 flags", {27'd0, out_word[29:28], out_word[3:0]}, {27'd0, e[29:28], 4'h0});
    chk("R7 status", {31'd0, out_word[30]}, {31'd0, e[30]});
    chk("R8 parity", {31'd0, out_word[31]}, {31'd0, e[31]});
    chk("R10 word", out_word, e);
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    rst = 1'b1;
    out_ready = 1'b0;
    randomize_inputs();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset valid", {31'd0, out_valid}, 32'd0);
    rst = 1'b0;
    // first cycle after reset: still not valid, load happens at next edge
    chk("R1 post-reset valid", {31'd0, out_valid}, 32'd0);
    step(1'b0);
    check_out();
    chk("R1 first sync", {30'd0, out_sync}, 32'd0);
    // directed: long stall holds word (R9)
    for (int i = 0; i < 5; i++) begin step(1'b0); check_out(); end
    // three blocks plus, random ready (R2 R3 R4 R5 R7 R8 R10)
    for (int i = 0; i < 3000; i++) begin
      step(($urandom % 4) != 0);
      check_out();
    end
    // directed full-throughput run across a wrap (R3)
    for (int i = 0; i < 2 * FRAMES * 2 + 4; i++) begin step(1'b1); check_out(); end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule